// File: doc/BRIEF.md
# Oversampling UART Receiver with Phase Resynchronisation

This block turns an asynchronous serial line into bytes. The frame is one start bit (low), eight data bits sent least-significant bit first, and one stop bit (high). The line idles high. A separate sample enable, `sample_tick`, is high for one clock sixteen times per bit period. All receive timing is counted in these ticks from the tick that first sees the line low after a high sample. The raw line passes through a two-flop synchronizer before anything looks at it.

Each bit is decided by a 2-of-3 vote over its 7th, 8th and 9th tick samples. This applies to the start bit as well. A start bit that votes high is treated as a glitch: the frame is dropped without a strobe. When a data edge arrives one tick before or one tick after the expected bit boundary, the receiver moves its tick count by one. This lets it follow a sender whose clock runs a little fast or slow. Once the stop bit has been voted, the receiver delivers the byte and goes back to hunting for a start edge at once. It does not wait for the end of the stop bit.

Output is a one-clock strobe carrying the byte and a framing-error flag. A serial line cannot be paused, so there is no ready input and no back-pressure: the consumer must take `rx_data` in the cycle `rx_valid` is high. `rx_data` holds its value until the next strobe.

Top module: `uart_rx_resync`

## Requirements
- R1: After reset, `rx_valid` and `rx_frame_err` are 0 and `rx_data` is 0x00.
- R2: A frame of 16-tick bits delivers exactly one `rx_valid` pulse. Bit k of `rx_data` is the k-th data bit received after the start bit (first received = bit 0). The pulse occurs in the clock after the tick that carries the stop bit's 9th sample.
- R3: Each bit's value is the majority of its 7th, 8th and 9th tick samples, counted from the first low tick of the start bit (which is sample 1). A single inverted sample among the three does not change the bit. Two inverted samples do.
- R4: If the start bit's majority is high, the frame is discarded with no `rx_valid`, and the next start edge is accepted normally.
- R5: If the stop bit's majority is low, `rx_frame_err` is 1 together with `rx_valid` and the byte is still delivered. With a high stop bit, `rx_frame_err` is 0.
- R6: Hunting for the next start edge resumes right after the stop bit's 9th sample. A stop bit only 9 ticks long, followed at once by a new start bit, yields two correct bytes.
- R7: A data-line transition seen at the 16th tick of a bit ends that bit one tick early. A transition seen at the 2nd tick of a data or stop bit restarts that bit's count. The adjustment is made at most once per bit and never for the start edge. With these rules, a 0x55 frame is received correctly from senders using 15-tick or 17-tick bits.
- R8: `rx_valid` is never high for two clocks in a row, and `rx_frame_err` is never high without `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | Sample enable, 16 pulses per bit period |
| serial_in | input | 1 | Raw asynchronous serial line, idle high |
| rx_data | output | 8 | Last received byte, held until the next strobe |
| rx_valid | output | 1 | One-clock strobe: a frame has completed |
| rx_frame_err | output | 1 | Stop bit voted low; valid only with rx_valid |

## Verification
The hardest behaviour to reach from the ports is the phase correction. The sender's edge must land exactly one tick off the boundary the receiver expects, and with a perfect sender this never happens. The bench generates the tick itself and times every line change in whole ticks. Each bit lasts a chosen number of ticks, so it can send frames with 15-tick and 17-tick bits. With 0x55 every boundary carries an edge, so the receiver must correct on every bit; without correction, the last data bit would be sampled inside its neighbour. The same tick-exact driving places single and double inverted samples on the vote taps. It also cuts the stop bit to 9 ticks to exercise the early re-arm.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_FRAME = 1'b1
  } rx_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[0] <= 1'b1;
          else        pipe[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[i] <= 1'b1;
          else        pipe[i] <= pipe[i-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/uart_rx_vote.sv
module uart_rx_vote #(
  parameter int OSR = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   run,
  input  logic [$clog2(OSR)-1:0] cnt,
  input  logic                   line,
  output logic                   vote_stb,
  output logic                   vote_bit
);
  import uart_rx_pkg::*;

  localparam int CNT_W = $clog2(OSR);
  localparam int MID   = OSR / 2;
  localparam logic [CNT_W-1:0] TAP_A = CNT_W'(MID - 2);
  localparam logic [CNT_W-1:0] TAP_B = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] TAP_C = CNT_W'(MID);

  logic samp_a, samp_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_a <= 1'b1;
      samp_b <= 1'b1;
    end else if (tick && run) begin
      if (cnt == TAP_A) samp_a <= line;
      if (cnt == TAP_B) samp_b <= line;
    end
  end

  assign vote_stb = tick && run && (cnt == TAP_C);
  assign vote_bit = maj3(samp_a, samp_b, line);
endmodule

// File: rtl/uart_rx_timer.sv
module uart_rx_timer #(
  parameter int OSR       = 16,
  parameter int DATA_BITS = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            tick,
  input  logic                            start,
  input  logic                            run,
  input  logic                            line,
  input  logic                            line_prev,
  output logic [$clog2(OSR)-1:0]          cnt,
  output logic [$clog2(DATA_BITS+2)-1:0]  idx
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(DATA_BITS + 1);

  logic corrected;
  logic edge_seen, early_edge, late_edge, at_last;

  always_comb begin
    edge_seen  = line ^ line_prev;
    at_last    = (cnt == CNT_LAST);
    early_edge = edge_seen && at_last && (idx < STOP_IDX);
    late_edge  = edge_seen && (cnt == CNT_ONE) && (idx != '0) && !corrected;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      idx       <= '0;
      corrected <= 1'b0;
    end else if (tick) begin
      if (start) begin
        cnt       <= CNT_ONE;
        idx       <= '0;
        corrected <= 1'b0;
      end else if (run) begin
        if (early_edge) begin
          cnt       <= CNT_ONE;
          idx       <= idx + IDX_W'(1);
          corrected <= 1'b1;
        end else if (late_edge) begin
          cnt       <= CNT_ONE;
          corrected <= 1'b1;
        end else if (at_last) begin
          cnt       <= '0;
          idx       <= idx + IDX_W'(1);
          corrected <= 1'b0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_resync.sv
module uart_rx_resync #(
  parameter int OSR         = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_tick,
  input  logic                 serial_in,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 rx_frame_err
);
  import uart_rx_pkg::*;

  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_BITS + 2);
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(DATA_BITS + 1);

  rx_state_t            state;
  logic                 line, line_prev;
  logic                 hunting, start_hit;
  logic [CNT_W-1:0]     bit_cnt;
  logic [IDX_W-1:0]     bit_idx;
  logic                 vote_stb, vote_bit;
  logic [DATA_BITS-1:0] shreg;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (serial_in),
    .q     (line)
  );

  assign hunting   = (state == ST_HUNT);
  assign start_hit = sample_tick && hunting && line_prev && !line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           line_prev <= 1'b1;
    else if (sample_tick) line_prev <= line;
  end

  uart_rx_timer #(.OSR(OSR), .DATA_BITS(DATA_BITS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sample_tick),
    .start     (start_hit),
    .run       (!hunting),
    .line      (line),
    .line_prev (line_prev),
    .cnt       (bit_cnt),
    .idx       (bit_idx)
  );

  uart_rx_vote #(.OSR(OSR)) u_vote (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sample_tick),
    .run      (!hunting),
    .cnt      (bit_cnt),
    .line     (line),
    .vote_stb (vote_stb),
    .vote_bit (vote_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_HUNT;
      shreg        <= '0;
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
    end else begin
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
      if (start_hit) begin
        state <= ST_FRAME;
      end else if (vote_stb) begin
        if (bit_idx == '0) begin
          if (vote_bit) state <= ST_HUNT;
        end else if (bit_idx == STOP_IDX) begin
          rx_data      <= shreg;
          rx_valid     <= 1'b1;
          rx_frame_err <= !vote_bit;
          state        <= ST_HUNT;
        end else begin
          shreg <= {vote_bit, shreg[DATA_BITS-1:1]};
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_resync_chk.sv
module uart_rx_resync_chk #(
  parameter int OSR       = 16,
  parameter int DATA_BITS = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            tick,
  input logic                            rx_valid,
  input logic                            rx_frame_err,
  input logic                            hunting,
  input logic [$clog2(DATA_BITS+2)-1:0]  bit_idx,
  input logic [$clog2(OSR)-1:0]          bit_cnt
);
  localparam int IDX_W = $clog2(DATA_BITS + 2);
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(DATA_BITS + 1);

  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r8_err_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_frame_err |-> rx_valid);

  a_r6_hunt_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> hunting);

  a_r2_strobe_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(tick));

  a_r2_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !hunting |-> (bit_idx <= STOP_IDX));

  a_r7_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !hunting) |=> $stable(bit_cnt));
endmodule

bind uart_rx_resync uart_rx_resync_chk #(.OSR(OSR), .DATA_BITS(DATA_BITS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (sample_tick),
  .rx_valid     (rx_valid),
  .rx_frame_err (rx_frame_err),
  .hunting      (hunting),
  .bit_idx      (bit_idx),
  .bit_cnt      (bit_cnt)
);

// File: tb/uart_rx_resync_bench.sv
module uart_rx_resync_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       serial_in = 1'b1;
  logic [7:0] rx_data;
  logic       rx_valid, rx_frame_err;

  always #4 clk = ~clk;

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
    tick <= (tdiv == 3);
  end

  uart_rx_resync u_uart_rx_resync (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_tick  (tick),
    .serial_in    (serial_in),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .rx_frame_err (rx_frame_err)
  );

  int checks = 0;
  int errors = 0;
  int got_cnt = 0;
  int long_pulse = 0;
  int lone_err = 0;
  logic prev_v = 1'b0;
  logic [7:0] got_data [4];
  logic       got_err  [4];

  always @(negedge clk) begin
    if (rx_valid) begin
      if (got_cnt < 4) begin
        got_data[got_cnt] = rx_data;
        got_err[got_cnt]  = rx_frame_err;
      end
      got_cnt++;
    end
    if (rx_valid && prev_v) long_pulse++;
    if (rx_frame_err && !rx_valid) lone_err++;
    prev_v = rx_valid;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (!tick);
    #1;
  endtask

  task automatic drive(input logic lvl, input int n);
    serial_in = lvl;
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  task automatic send_frame(input logic [7:0] b, input int blen,
                            input int slen, input logic slev);
    drive(1'b0, blen);
    for (int i = 0; i < 8; i++) drive(b[i], blen);
    drive(slev, slen);
  endtask

  task automatic t_reset();
    chk("R1 rx_valid after reset", rx_valid, 0);
    chk("R1 rx_frame_err after reset", rx_frame_err, 0);
    chk("R1 rx_data after reset", rx_data, 0);
  endtask

  task automatic t_nominal();
    logic [7:0] pats [5] = '{8'hA5, 8'h00, 8'hFF, 8'h01, 8'h80};
    for (int k = 0; k < 5; k++) begin
      got_cnt = 0;
      send_frame(pats[k], 16, 16, 1'b1);
      drive(1'b1, 8);
      chk("R2 strobe count", got_cnt, 1);
      chk("R2 byte LSB first", got_data[0], pats[k]);
      chk("R5 no framing error", got_err[0], 0);
    end
  endtask

  task automatic t_glitch();
    got_cnt = 0;
    drive(1'b0, 3);
    drive(1'b1, 30);
    chk("R4 short glitch discarded", got_cnt, 0);
    drive(1'b0, 7);
    drive(1'b1, 30);
    chk("R4 7-tick low start discarded", got_cnt, 0);
    send_frame(8'h3C, 16, 16, 1'b1);
    drive(1'b1, 8);
    chk("R4 next frame count", got_cnt, 1);
    chk("R4 next frame byte", got_data[0], 8'h3C);
  endtask

  task automatic t_majority();
    logic [7:0] b = 8'hC3;
    got_cnt = 0;
    drive(1'b0, 16);
    for (int i = 0; i < 8; i++) begin
      drive(b[i], 7);
      drive(!b[i], 1);
      drive(b[i], 8);
    end
    drive(1'b1, 24);
    chk("R3 single flipped sample count", got_cnt, 1);
    chk("R3 single flipped sample byte", got_data[0], 8'hC3);
    got_cnt = 0;
    drive(1'b0, 16);
    for (int i = 0; i < 8; i++) begin
      if (i == 2) begin
        drive(1'b0, 6);
        drive(1'b1, 2);
        drive(1'b0, 8);
      end else begin
        drive(1'b0, 16);
      end
    end
    drive(1'b1, 24);
    chk("R3 two flipped samples win", got_data[0], 8'h04);
  endtask

  task automatic t_framing();
    got_cnt = 0;
    send_frame(8'h5A, 16, 16, 1'b0);
    drive(1'b1, 20);
    chk("R5 strobe with bad stop", got_cnt, 1);
    chk("R5 framing error set", got_err[0], 1);
    chk("R5 byte still delivered", got_data[0], 8'h5A);
    got_cnt = 0;
    send_frame(8'h77, 16, 16, 1'b1);
    drive(1'b1, 8);
    chk("R5 recovery byte", got_data[0], 8'h77);
    chk("R5 recovery flag clear", got_err[0], 0);
  endtask

  task automatic t_rearm();
    got_cnt = 0;
    send_frame(8'h12, 16, 9, 1'b1);
    send_frame(8'h34, 16, 16, 1'b1);
    drive(1'b1, 8);
    chk("R6 two strobes", got_cnt, 2);
    chk("R6 first byte", got_data[0], 8'h12);
    chk("R6 second byte", got_data[1], 8'h34);
  endtask

  task automatic t_phase();
    got_cnt = 0;
    send_frame(8'h55, 17, 17, 1'b1);
    drive(1'b1, 8);
    chk("R7 slow sender count", got_cnt, 1);
    chk("R7 slow sender byte", got_data[0], 8'h55);
    chk("R7 slow sender stop", got_err[0], 0);
    got_cnt = 0;
    send_frame(8'h55, 15, 15, 1'b1);
    drive(1'b1, 8);
    chk("R7 fast sender count", got_cnt, 1);
    chk("R7 fast sender byte", got_data[0], 8'h55);
    chk("R7 fast sender stop", got_err[0], 0);
  endtask

  task automatic t_pulse();
    chk("R8 strobe never two cycles", long_pulse, 0);
    chk("R8 error flag only with strobe", lone_err, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    serial_in = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    drive(1'b1, 4);
    t_reset();
    t_nominal();
    t_glitch();
    t_majority();
    t_framing();
    t_rearm();
    t_phase();
    t_pulse();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule